// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Vote

This block receives asynchronous serial characters on a single input line. It runs at sixteen oversample ticks per bit. The tick comes from one of four sources, chosen by a two-bit selector: a baud-rate tick, a tick on every system clock, a timer trigger, or the rising edge of an external clock pin.

The line is first passed through a two-flop synchronizer. While the receiver is idle, a falling edge on the synchronized line clears a four-bit tick counter and starts qualification of the start bit. Every bit, the start bit included, is sampled on the 7th, 8th and 9th ticks of its sixteen-tick period, and its value is the 2-of-3 majority of those samples. A start bit that votes high is treated as noise, and the receiver returns to idle. An accepted start bit is followed by eight data bits, least significant first, and then one stop bit.

At the end of the stop bit the assembled byte is presented with a one-cycle valid strobe. A framing error flag is loaded at the same time and holds until the next strobe.

Top module: `uart_os_rx`

## Requirements
- R1: `src_sel` picks the tick source: 0 selects `tick_baud`, 1 selects `tick_sys`, 2 selects `tick_timer`, and 3 selects a rising edge of `ext_clk`. Activity on the unselected sources has no effect on the decoded data.
- R2: The internal tick counter advances only on a selected tick and wraps after 16 ticks, so each bit lasts exactly 16 selected ticks.
- R3: Each bit is sampled on the 7th, 8th and 9th ticks of its period. Line changes on ticks 1 to 6 and 10 to 16 do not change the result.
- R4: A bit's value is the majority of its three samples. For example, 1,0,1 resolves to 1 and 0,0,1 resolves to 0.
- R5: While idle, a falling edge on the synchronized line begins start-bit qualification. The start bit is accepted when at least two of its three samples are 0. Otherwise the receiver returns to idle and produces no strobe.
- R6: A frame is a start bit, then 8 data bits with the least significant bit first, then one stop bit. The data bits appear on `rx_byte[0]` through `rx_byte[7]` in arrival order.
- R7: `rx_valid` is high for exactly one clock cycle per accepted frame. `rx_byte` changes only in that cycle.
- R8: In the strobe cycle, `rx_ferr` is 1 when the stop bit resolves to 0 and 0 when it resolves to 1. The byte is presented in either case. `rx_ferr` holds its value between strobes.
- R9: Synchronous active-high reset clears `rx_byte`, `rx_valid` and `rx_ferr` to 0 and leaves the receiver idle.
- R10: `rxd` passes through a two-flop synchronizer before edge detection and sampling. With the system-clock source, the three samples fall on the 7th, 8th and 9th clock cycles after the first low cycle presented on `rxd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_baud | input | 1 | Single-cycle tick from the baud-rate generator |
| tick_sys | input | 1 | System-rate tick enable |
| tick_timer | input | 1 | Single-cycle timer trigger |
| ext_clk | input | 1 | External oversample clock level (rising edges count) |
| src_sel | input | 2 | Tick source select (0 baud, 1 system, 2 timer, 3 external) |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe marking a new byte |
| rx_ferr | output | 1 | Stop bit of the last frame resolved low |

## Verification
The assertions assume that `src_sel` changes only while the receiver is idle, and that the external clock stays high and low for at least one system cycle each, so its rising edges never come on consecutive cycles. The stimulus changes the selector only in the quiet gap between frames and toggles `ext_clk` every two cycles. The tests that flip individual samples run only with the system-clock source. There the sample positions relative to the line are fixed by R10, and the bench can place each flip on a known oversample position.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        SRC_BAUD  = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_EXT   = 2'd3
    } tick_src_e;

    localparam int VOTE_TAPS = 3;

    // 2-of-3 majority
    function automatic logic vote3(input logic [VOTE_TAPS-1:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_mux.sv
module rx_tick_mux
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_baud,
    input  logic       tick_sys,
    input  logic       tick_timer,
    input  logic       ext_clk,
    input  logic [1:0] src_sel,
    output logic       tick
);
    logic ext_s;
    logic ext_prev;
    logic ext_rise;

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_clk),
        .q   (ext_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= 1'b0;
        else     ext_prev <= ext_s;
    end

    assign ext_rise = ext_s & ~ext_prev;

    always_comb begin
        unique case (tick_src_e'(src_sel))
            SRC_BAUD:  tick = tick_baud;
            SRC_SYS:   tick = tick_sys;
            SRC_TIMER: tick = tick_timer;
            SRC_EXT:   tick = ext_rise;
            default:   tick = 1'b0;
        endcase
    end

    // edge-derived ticks can never arrive on two consecutive cycles
    AST_EXT_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_EXT && tick) |=> (src_sel != SRC_EXT || !tick)); // R1
endmodule

// File: rtl/rx_frame_core.sv
module rx_frame_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd_s,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_ferr
);
    localparam int CNT_W     = $clog2(OVS);
    localparam int BIT_W     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int SMP_LAST  = OVS / 2;          // cnt value on the 9th tick
    localparam int SMP_FIRST = SMP_LAST - 2;     // cnt value on the 7th tick
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(SMP_FIRST);
    localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(SMP_LAST);
    localparam logic [BIT_W-1:0] BIT_END = BIT_W'(DATA_BITS - 1);

    rx_state_e              state;
    logic [CNT_W-1:0]       cnt;
    logic [VOTE_TAPS-1:0]   smp;
    logic [BIT_W-1:0]       bit_idx;
    logic [DATA_BITS-1:0]   shreg;
    logic                   rxd_prev;
    logic                   fall;
    logic                   bit_val;
    logic                   in_window;
    logic                   period_end;

    assign fall       = rxd_prev & ~rxd_s;
    assign bit_val    = vote3(smp);
    assign in_window  = (cnt >= CNT_LO) && (cnt <= CNT_HI);
    assign period_end = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            smp      <= '1;
            bit_idx  <= '0;
            shreg    <= '0;
            rxd_prev <= 1'b1;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rxd_prev <= rxd_s;
            rx_valid <= 1'b0;
            if (state == RX_IDLE) begin
                if (fall) begin
                    state <= RX_START;
                    cnt   <= '0;
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                if (in_window) smp <= {rxd_s, smp[VOTE_TAPS-1:1]};
                if (period_end) begin
                    unique case (state)
                        RX_START: begin
                            bit_idx <= '0;
                            state   <= bit_val ? RX_IDLE : RX_DATA;
                        end
                        RX_DATA: begin
                            shreg <= {bit_val, shreg[DATA_BITS-1:1]};
                            if (bit_idx == BIT_END) state <= RX_STOP;
                            else                    bit_idx <= bit_idx + 1'b1;
                        end
                        RX_STOP: begin
                            rx_byte  <= shreg;
                            rx_ferr  <= ~bit_val;
                            rx_valid <= 1'b1;
                            state    <= RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
            end
        end
    end

    AST_CNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (state != RX_IDLE && !tick) |=> $stable(cnt)); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state != RX_IDLE && tick && period_end) |=> (cnt == '0)); // R2
    AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && $past(state) == RX_IDLE) |-> !$past(rxd_s)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R7
    AST_VALID_BACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (state == RX_IDLE)); // R7
    AST_BYTE_ONLY_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> rx_valid); // R7
    AST_FERR_ONLY_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_ferr) |-> rx_valid); // R8
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_baud,
    input  logic                 tick_sys,
    input  logic                 tick_timer,
    input  logic                 ext_clk,
    input  logic [1:0]           src_sel,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_ferr
);
    logic tick;
    logic rxd_s;

    rx_tick_mux #(.SYNC_STAGES(SYNC_STAGES)) u_tick_mux (
        .clk        (clk),
        .rst        (rst),
        .tick_baud  (tick_baud),
        .tick_sys   (tick_sys),
        .tick_timer (tick_timer),
        .ext_clk    (ext_clk),
        .src_sel    (src_sel),
        .tick       (tick)
    );

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rxd_s)
    );

    rx_frame_core #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxd_s    (rxd_s),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr)
    );
endmodule

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_baud = 1'b0;
    logic       tick_sys = 1'b1;
    logic       tick_timer = 1'b0;
    logic       ext_clk = 1'b0;
    logic [1:0] src_sel = 2'd1;
    logic       rxd = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_ferr;

    int n_chk = 0;
    int n_bad = 0;
    int v_cnt = 0;
    logic [7:0] cap_byte = 8'h00;
    logic       cap_ferr = 1'b0;
    logic       last_v = 1'b0;
    logic [15:0] fmask [10];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_os_rx u_dut (
        .clk(clk), .rst(rst), .tick_baud(tick_baud), .tick_sys(tick_sys),
        .tick_timer(tick_timer), .ext_clk(ext_clk), .src_sel(src_sel),
        .rxd(rxd), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // tick sources: baud every 2 cycles, timer every 3, external toggles every 2
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            tick_baud  <= (k % 2 == 0);
            tick_timer <= (k % 3 == 0);
            if (k % 2 == 0) ext_clk <= ~ext_clk;
        end
    end

    // output monitor, R7 pulse width
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                v_cnt++;
                cap_byte = rx_byte;
                cap_ferr = rx_ferr;
                if (last_v) chk(1'b0, "R7", "valid wider than one cycle", 1, 0);
            end
            last_v = rx_valid;
        end
    end

    task automatic clr_mask();
        for (int i = 0; i < 10; i++) fmask[i] = 16'h0000;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input int cpt);
        for (int i = 0; i < 10; i++) begin
            logic v;
            v = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
            for (int c = 0; c < 16 * cpt; c++) begin
                @(negedge clk);
                rxd <= v ^ ((cpt == 1) ? fmask[i][c[3:0]] : 1'b0);
            end
        end
        @(negedge clk);
        rxd <= 1'b1;
        repeat (24 * cpt) @(negedge clk);
    endtask

    task automatic expect_frame(input logic [7:0] b, input logic stop, input int cpt,
                                input logic [7:0] exp_b, input logic exp_f, input string req);
        int v0;
        v0 = v_cnt;
        send_frame(b, stop, cpt);
        chk(v_cnt == v0 + 1, req, "strobe count", v_cnt - v0, 1);
        chk(cap_byte == exp_b, req, "byte", cap_byte, exp_b);
        chk(cap_ferr == exp_f, req, "framing flag", cap_ferr, exp_f);
    endtask

    task automatic false_start(input int low_len, input string req);
        int v0;
        v0 = v_cnt;
        for (int c = 0; c < low_len; c++) begin
            @(negedge clk);
            rxd <= 1'b0;
        end
        @(negedge clk);
        rxd <= 1'b1;
        repeat (300) @(negedge clk);
        chk(v_cnt == v0, req, "no strobe after rejected start", v_cnt - v0, 0);
    endtask

    initial begin
        clr_mask();
        repeat (4) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(rx_valid == 1'b0, "R9", "valid after reset", rx_valid, 0);
        chk(rx_byte == 8'h00, "R9", "byte after reset", rx_byte, 0);
        chk(rx_ferr == 1'b0, "R9", "ferr after reset", rx_ferr, 0);
        repeat (20) @(negedge clk);

        // R6 full byte sweep, system tick source
        for (int b = 0; b < 256; b++) expect_frame(8'(b), 1'b1, 1, 8'(b), 1'b0, "R6");

        // R8 framing error, value held, then cleared
        expect_frame(8'hA5, 1'b0, 1, 8'hA5, 1'b1, "R8");
        repeat (100) @(negedge clk);
        chk(rx_ferr == 1'b1, "R8", "ferr held between strobes", rx_ferr, 1);
        chk(rx_byte == 8'hA5, "R7", "byte held between strobes", rx_byte, 8'hA5);
        expect_frame(8'h3C, 1'b1, 1, 8'h3C, 1'b0, "R8");

        // R4 vote: samples 1,0,1 -> 1 on data bit 0 of 0x00
        clr_mask(); fmask[1] = 16'h0280;
        expect_frame(8'h00, 1'b1, 1, 8'h01, 1'b0, "R4");
        // R4 vote: samples 0,0,1 -> 0 on data bit 3 of 0xFF
        clr_mask(); fmask[4] = 16'h0180;
        expect_frame(8'hFF, 1'b1, 1, 8'hF7, 1'b0, "R4");
        // R4 single flip at the middle sample of every data bit: no effect
        clr_mask();
        for (int i = 1; i < 9; i++) fmask[i] = 16'h0100;
        expect_frame(8'h5A, 1'b1, 1, 8'h5A, 1'b0, "R4");
        // R4 stop bit with one low sample still good, two low samples -> error
        clr_mask(); fmask[9] = 16'h0100;
        expect_frame(8'h66, 1'b1, 1, 8'h66, 1'b0, "R4");
        clr_mask(); fmask[9] = 16'h0300;
        expect_frame(8'h66, 1'b1, 1, 8'h66, 1'b1, "R8");

        // R3 / R10 changes outside positions 7..9 are ignored
        clr_mask();
        for (int i = 1; i < 9; i++) fmask[i] = 16'hFC7F;
        expect_frame(8'h96, 1'b1, 1, 8'h96, 1'b0, "R3");
        // R10 flips on positions 6 and 10 only: ignored
        clr_mask();
        for (int i = 1; i < 9; i++) fmask[i] = 16'h0440;
        expect_frame(8'hC3, 1'b1, 1, 8'hC3, 1'b0, "R10");
        clr_mask();

        // R5 start qualification
        false_start(5, "R5");
        false_start(8, "R5");
        fmask[0] = 16'hFE00;   // start low on positions 0..8 only: votes 0,0,1
        expect_frame(8'hFF, 1'b1, 1, 8'hFF, 1'b0, "R5");
        clr_mask();
        expect_frame(8'h81, 1'b1, 1, 8'h81, 1'b0, "R5");

        // R1 / R2 other tick sources, changed while idle
        src_sel <= 2'd0;
        expect_frame(8'h0F, 1'b1, 2, 8'h0F, 1'b0, "R1");
        expect_frame(8'hB2, 1'b0, 2, 8'hB2, 1'b1, "R1");
        src_sel <= 2'd2;
        expect_frame(8'h4D, 1'b1, 3, 8'h4D, 1'b0, "R1");
        expect_frame(8'hE1, 1'b1, 3, 8'hE1, 1'b0, "R2");
        src_sel <= 2'd3;
        expect_frame(8'h72, 1'b1, 4, 8'h72, 1'b0, "R1");
        expect_frame(8'h1E, 1'b1, 4, 8'h1E, 1'b0, "R2");
        src_sel <= 2'd1;
        expect_frame(8'h99, 1'b1, 1, 8'h99, 1'b0, "R1");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule